// File: doc/BRIEF.md
# ADC sample FIFO with about-counter

This block sits between an analog-to-digital conversion engine and a host read port. Each converted 16-bit sample is pushed into a first-in first-out store. The host pops samples one at a time and watches a status word that reports whether the store holds data, whether it is less than half occupied, and whether it still has room. The store depth is a build-time parameter, and only the two supported sizes are legal.

A reloadable 16-bit sample counter watches accepted writes. It produces a one-cycle event each time a programmed number of samples has arrived, which the host uses as a block-transfer interrupt. If its stop option is set, an expiry also raises a halt output that holds back further conversions. Writes that arrive when the store is full are lost and recorded in a sticky overrun word, which the host clears explicitly.

Top module: `smp_fifo_acnt`

## Requirements
- R1: The depth parameter `DEPTH` must be 1024 or 8192. Any other value is rejected at elaboration.
- R2: `fifo_status` bit 8 is 1 while the store holds at least one word. Bit 9 is 1 while fewer than `DEPTH/2` words are held. Bit 10 is 1 while fewer than `DEPTH` words are held. All other bits are 0. After reset the store is empty, so the status reads 16'h0600, and `host_rdata` reads 0.
- R3: Samples leave in the order they were written. A `host_rd` strobe on a non-empty store places the oldest word on `host_rdata` after the same clock edge and removes it.
- R4: A `host_rd` strobe on an empty store leaves `host_rdata`, the pointers and the status unchanged.
- R5: A write and a read in the same cycle on a store that is neither empty nor full leave the occupancy unchanged.
- R6: A `fifo_clr` strobe empties the store, whatever `smp_wdata` holds. A write or read in the same cycle is discarded. The clear does not touch the sample counter or the overrun word.
- R7: A strobe on `acnt_load` keeps only bits 15:0 of `acnt_wdata` as the value N. The counter then raises `acnt_evt` for one cycle after every N+1 accepted writes. After each expiry it reloads N by itself. After reset N is `DEPTH/2-1`.
- R8: A write (not halted, not cleared) while the store is full is dropped and leaves the store unchanged. It makes `ovr_word` nonzero, and `ovr_word` stays nonzero until an `ovr_clr` strobe returns it to 0.
- R9: When `acnt_stop_en` is 1 and the counter expires, `conv_halt` rises after that edge. While it is high, sample writes are discarded and do not count as overruns. An `acnt_load` strobe releases it. With `acnt_stop_en` at 0, `conv_halt` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_wr | input | 1 | Sample write strobe from the converter |
| smp_wdata | input | 16 | Sample word to store |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Last word popped by the host |
| fifo_clr | input | 1 | Empties the store |
| acnt_load | input | 1 | Loads the sample counter period |
| acnt_wdata | input | 32 | Load value; only bits 15:0 are kept |
| acnt_stop_en | input | 1 | Counter expiry halts conversions |
| ovr_clr | input | 1 | Clears the overrun word |
| fifo_status | output | 16 | Status word: bit 8 not-empty, bit 9 half-empty, bit 10 not-full |
| ovr_word | output | 16 | Sticky overrun record, nonzero after a lost write |
| acnt_evt | output | 1 | One-cycle counter expiry event |
| conv_halt | output | 1 | Request to stop further conversions |

## Verification
Every result of this block is registered once. The status bits, `host_rdata`, `ovr_word` and `conv_halt` show the effect of a strobe right after the clock edge that takes it. `acnt_evt` is high for exactly the one cycle that follows the edge of the expiring write. The bench drives each strobe just after a falling edge and holds it across exactly one rising edge. It then compares every output at the next falling edge, so each check lands in the single cycle where the result is due. The check one step later confirms that the event pulse has dropped.

// File: rtl/smpf_pkg.sv
package smpf_pkg;

    localparam int SMP_W = 16;
    localparam int ST_NE = 8;
    localparam int ST_HE = 9;
    localparam int ST_NF = 10;

    // Assemble the host-visible status word from the three occupancy flags.
    function automatic logic [SMP_W-1:0] pack_status(logic ne, logic he, logic nf);
        logic [SMP_W-1:0] w;
        w        = '0;
        w[ST_NE] = ne;
        w[ST_HE] = he;
        w[ST_NF] = nf;
        return w;
    endfunction

endpackage

// File: rtl/smpf_store.sv
module smpf_store
    import smpf_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic                     clr,
    input  logic [SMP_W-1:0]         wdata,
    output logic [SMP_W-1:0]         rdata,
    output logic [$clog2(DEPTH):0]   count
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CW-1:0]    cnt;
        logic [SMP_W-1:0] rd;
    } store_t;

    store_t           st_d, st_q;
    logic [SMP_W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.wp = st_q.wp + 1'b1;
            end
            if (pop) begin
                st_d.rp = st_q.rp + 1'b1;
                st_d.rd = mem[st_q.rp];
            end
            if (push && !pop) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (pop && !push) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[st_q.wp] <= wdata;
        end
    end

    assign rdata = st_q.rd;
    assign count = st_q.cnt;

    // R2: occupancy never exceeds the depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R6: a clear strobe leaves the store empty
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

endmodule

// File: rtl/smpf_about.sv
module smpf_about
    import smpf_pkg::*;
#(
    parameter logic [SMP_W-1:0] RST_PERIOD = 16'd511
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [SMP_W-1:0] ld_val,
    input  logic             tick,
    input  logic             stop_en,
    output logic             evt,
    output logic             halt
);

    typedef struct packed {
        logic [SMP_W-1:0] cur;
        logic [SMP_W-1:0] rel;
        logic             evt;
        logic             halt;
    } about_t;

    about_t ab_d, ab_q;

    always_comb begin
        ab_d     = ab_q;
        ab_d.evt = 1'b0;
        if (ld) begin
            ab_d.rel  = ld_val;
            ab_d.cur  = ld_val;
            ab_d.halt = 1'b0;
        end else if (tick) begin
            if (ab_q.cur == '0) begin
                ab_d.cur = ab_q.rel;
                ab_d.evt = 1'b1;
                if (stop_en) begin
                    ab_d.halt = 1'b1;
                end
            end else begin
                ab_d.cur = ab_q.cur - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ab_q.cur  <= RST_PERIOD;
            ab_q.rel  <= RST_PERIOD;
            ab_q.evt  <= 1'b0;
            ab_q.halt <= 1'b0;
        end else begin
            ab_q <= ab_d;
        end
    end

    assign evt  = ab_q.evt;
    assign halt = ab_q.halt;

    // R7: an accepted write at count zero produces the event next cycle
    p_expiry_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && ab_q.cur == '0) |=> evt);

    // R9: the halt holds until a load releases it
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !ld) |=> halt);

endmodule

// File: rtl/smpf_ovr.sv
module smpf_ovr
    import smpf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lost,
    input  logic             clr,
    output logic [SMP_W-1:0] word
);

    typedef struct packed {
        logic [SMP_W-1:0] cnt;
    } ovr_t;

    ovr_t ov_d, ov_q;

    always_comb begin
        ov_d = ov_q;
        if (clr) begin
            ov_d.cnt = '0;
        end else if (lost && (ov_q.cnt != '1)) begin
            ov_d.cnt = ov_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q <= '0;
        end else begin
            ov_q <= ov_d;
        end
    end

    assign word = ov_q.cnt;

    // R8: once nonzero the word stays nonzero until cleared
    p_sticky_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word != '0 && !clr) |=> (word != '0));

endmodule

// File: rtl/smp_fifo_acnt.sv
module smp_fifo_acnt
    import smpf_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_wr,
    input  logic [15:0] smp_wdata,
    input  logic        host_rd,
    output logic [15:0] host_rdata,
    input  logic        fifo_clr,
    input  logic        acnt_load,
    input  logic [31:0] acnt_wdata,
    input  logic        acnt_stop_en,
    input  logic        ovr_clr,
    output logic [15:0] fifo_status,
    output logic [15:0] ovr_word,
    output logic        acnt_evt,
    output logic        conv_halt
);

    localparam int               CW         = $clog2(DEPTH) + 1;
    localparam int               HALF       = DEPTH / 2;
    localparam logic [SMP_W-1:0] RST_PERIOD = SMP_W'(HALF - 1);

    // R1: only the two supported depths are legal
    initial begin
        p_depth_legal_r1: assert (DEPTH == 1024 || DEPTH == 8192);
    end

    logic [CW-1:0] count;
    logic          not_empty, half_empty, not_full;
    logic          push, pop, lost;

    assign not_empty  = (count != '0);
    assign half_empty = (count < CW'(HALF));
    assign not_full   = (count != CW'(DEPTH));

    assign push = smp_wr && !conv_halt && not_full && !fifo_clr;
    assign lost = smp_wr && !conv_halt && !not_full && !fifo_clr;
    assign pop  = host_rd && not_empty && !fifo_clr;

    smpf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .clr   (fifo_clr),
        .wdata (smp_wdata),
        .rdata (host_rdata),
        .count (count)
    );

    smpf_about #(.RST_PERIOD(RST_PERIOD)) u_about (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (acnt_load),
        .ld_val  (acnt_wdata[SMP_W-1:0]),
        .tick    (push),
        .stop_en (acnt_stop_en),
        .evt     (acnt_evt),
        .halt    (conv_halt)
    );

    smpf_ovr u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .lost  (lost),
        .clr   (ovr_clr),
        .word  (ovr_word)
    );

    assign fifo_status = pack_status(not_empty, half_empty, not_full);

    // R4: a read on an empty store leaves the read data untouched
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !not_empty) |=> $stable(host_rdata));

    // R5: a simultaneous write and read keep the occupancy
    p_rw_balance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_wr && host_rd && not_empty && not_full && !conv_halt && !fifo_clr)
        |=> $stable(count));

    // R8: a lost write leaves a nonzero overrun word
    p_lost_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_wr && !conv_halt && !not_full && !fifo_clr && !ovr_clr)
        |=> (ovr_word != '0));

    // R9: a halted write does not change the occupancy
    p_halt_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_halt && smp_wr && !host_rd && !fifo_clr) |=> $stable(count));

endmodule

// File: tb/smp_fifo_acnt_bench.sv
module smp_fifo_acnt_bench;

    localparam int DEPTH = 1024;
    localparam int NVEC  = 9;

    // {op[34:33] (1 write, 2 read, 3 both), wdata[32:17], exp rdata[16:1], exp not-empty[0]}
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd1, 16'hA001, 16'h0000, 1'b1},
        {2'd1, 16'hA002, 16'h0000, 1'b1},
        {2'd2, 16'h0000, 16'hA001, 1'b1},
        {2'd3, 16'hA003, 16'hA002, 1'b1},
        {2'd2, 16'h0000, 16'hA003, 1'b0},
        {2'd2, 16'h0000, 16'hA003, 1'b0},
        {2'd1, 16'hA004, 16'hA003, 1'b1},
        {2'd3, 16'hA005, 16'hA004, 1'b1},
        {2'd2, 16'h0000, 16'hA005, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_wr = 1'b0;
    logic [15:0] smp_wdata = '0;
    logic        host_rd = 1'b0;
    logic [15:0] host_rdata;
    logic        fifo_clr = 1'b0;
    logic        acnt_load = 1'b0;
    logic [31:0] acnt_wdata = '0;
    logic        acnt_stop_en = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [15:0] fifo_status;
    logic [15:0] ovr_word;
    logic        acnt_evt;
    logic        conv_halt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    smp_fifo_acnt #(.DEPTH(DEPTH)) u_smp_fifo_acnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_wr       (smp_wr),
        .smp_wdata    (smp_wdata),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .fifo_clr     (fifo_clr),
        .acnt_load    (acnt_load),
        .acnt_wdata   (acnt_wdata),
        .acnt_stop_en (acnt_stop_en),
        .ovr_clr      (ovr_clr),
        .fifo_status  (fifo_status),
        .ovr_word     (ovr_word),
        .acnt_evt     (acnt_evt),
        .conv_halt    (conv_halt)
    );

    function automatic logic [15:0] st(logic ne, logic he, logic nf);
        return {5'b0, nf, he, ne, 8'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Holds the strobes across exactly one rising edge; returns at a falling edge.
    task automatic step(input logic w, input logic r, input logic c,
                        input logic ld, input logic oc, input logic [15:0] d);
        smp_wr = w; host_rd = r; fifo_clr = c; acnt_load = ld; ovr_clr = oc;
        smp_wdata = d;
        @(negedge clk);
        smp_wr = 1'b0; host_rd = 1'b0; fifo_clr = 1'b0; acnt_load = 1'b0; ovr_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk("R2 reset status", fifo_status, 16'h0600);
        chk("R2 reset rdata", host_rdata, 16'h0000);
        chk("R8 reset overrun", ovr_word, 16'h0000);
        chk("R7 reset event", acnt_evt, 1'b0);
        chk("R9 reset halt", conv_halt, 1'b0);

        // R3 R4 R5 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            op = VEC[i][34:33];
            step(op[0], op[1], 1'b0, 1'b0, 1'b0, VEC[i][32:17]);
            chk($sformatf("R3 R4 R5 vector %0d rdata", i), host_rdata, VEC[i][16:1]);
            chk($sformatf("R2 vector %0d status", i), fifo_status, st(VEC[i][0], 1'b1, 1'b1));
        end

        // R7 truncated load: N = 2, events after every third write
        acnt_wdata = 32'hABCD_0002;
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        for (int k = 1; k <= 6; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'(k));
            chk($sformatf("R7 event after write %0d", k), acnt_evt, (k % 3) == 0);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R7 event is one cycle", acnt_evt, 1'b0);
        chk("R9 no halt without stop enable", conv_halt, 1'b0);

        // R6 clear with a concurrent write
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hDEAD);
        chk("R6 clear empties", fifo_status, 16'h0600);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R4 R6 read after clear keeps data", host_rdata, 16'hA005);

        // R2 R7 R8 fill to the top with the usual period
        acnt_wdata = 32'(DEPTH / 2 - 1);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'(i));
            if (i == DEPTH / 2 - 2) begin
                chk("R2 half-empty below half", fifo_status, st(1'b1, 1'b1, 1'b1));
                chk("R7 no early event", acnt_evt, 1'b0);
            end
            if (i == DEPTH / 2 - 1) begin
                chk("R2 half-empty drops at half", fifo_status, st(1'b1, 1'b0, 1'b1));
                chk("R7 event at half depth", acnt_evt, 1'b1);
            end
        end
        chk("R2 full status", fifo_status, st(1'b1, 1'b0, 1'b0));
        chk("R7 event at full depth", acnt_evt, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF);
        chk("R8 overrun set", ovr_word != 16'h0, 1'b1);
        chk("R8 full unchanged", fifo_status, st(1'b1, 1'b0, 1'b0));
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R3 R8 oldest word survives", host_rdata, 16'h0000);
        chk("R2 not-full after read", fifo_status, st(1'b1, 1'b0, 1'b1));
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234);
        chk("R8 overrun sticky", ovr_word != 16'h0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        chk("R8 overrun cleared", ovr_word, 16'h0000);

        // R9 stop on count, N = 1
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        acnt_wdata   = 32'h0000_0001;
        acnt_stop_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hB001);
        chk("R9 no halt before expiry", conv_halt, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hB002);
        chk("R9 halt at expiry", conv_halt, 1'b1);
        chk("R7 R9 event at expiry", acnt_evt, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hB003);
        chk("R9 halt holds", conv_halt, 1'b1);
        chk("R9 halted write no overrun", ovr_word, 16'h0000);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R9 first word", host_rdata, 16'hB001);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R9 second word", host_rdata, 16'hB002);
        chk("R9 halted write discarded", fifo_status, 16'h0600);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        chk("R9 load releases halt", conv_halt, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hB004);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R9 write after release", host_rdata, 16'hB004);
        acnt_stop_en = 1'b0;

        finish_run();
    end

endmodule